// File: doc/BRIEF.md
# Prioritised Memory Select Decoder

This block turns a 16-bit bus address into chip selects for a small memory map: eight main flash sectors, four boot flash sectors, one SRAM, one I/O space and one peripheral space. Each select is driven by a programmable window. A window has an enable bit, a base address and a compare mask. The SRAM select is the OR of two independent windows, so it can cover two separate regions. The selects are combinational from the address and the stored windows.

Windows may overlap on purpose. When they do, a fixed class priority picks a single winner, so at most one select is active at a time. Some overlaps break the mapping rules, and so do flash windows larger than the physical sector. These set a sticky configuration-error flag, which clears only on reset. Software loads the windows one field at a time through a plain write port.

Top module: `memsel_decoder`

## Requirements
- R1: After reset every window is disabled, with base and mask zero. No select is asserted for any address, and `cfg_err` is 0.
- R2: Window i matches when it is enabled and `(bus_addr & mask_i) == (base_i & mask_i)`. A mask bit of 1 means the address bit is compared. A disabled window never matches.
- R3: `sram_sel` is asserted when either of the two SRAM windows matches. Two SRAM windows that overlap each other are legal and do not set `cfg_err`.
- R4: When a boot flash window and a main flash window both match, only the boot flash select is asserted.
- R5: When the SRAM, I/O or peripheral window matches, no flash select is asserted. Among these three, SRAM wins over I/O, and I/O wins over peripheral.
- R6: All the selects together are one-hot or all zero. Within a class, the lowest-numbered matching window wins.
- R7: Some overlaps set `cfg_err` at the next clock edge: two main flash windows that both match `bus_addr`, two boot flash windows that both match it, or more than one of SRAM, I/O and peripheral matching it.
- R8: A write that enables a flash window whose mask has more zero bits than the sector address width sets `cfg_err` at that write's clock edge. The sector address width is 13 for main flash and 12 for boot flash. Writes with the enable bit 0 are not checked, and neither are writes to non-flash windows.
- R9: Once set, `cfg_err` stays 1 until reset.
- R10: A write with `cfg_we`=1 uses `cfg_addr[4:1]` as the window index and `cfg_addr[0]` as the field. Indices 0–7 are main flash sectors 0–7, 8–11 are boot flash sectors 0–3, 12–13 are the two SRAM windows, 14 is I/O and 15 is peripheral. Field 0 loads the base from `cfg_wdata[15:0]`. Field 1 loads the mask from `cfg_wdata[15:0]` and the enable from `cfg_wdata[16]`. The new window applies from the clock edge that takes the write.
- R11: An address that matches no enabled window asserts no select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cfg_we | input | 1 | Window register write strobe |
| cfg_addr | input | 5 | Window index (bits 4:1) and field (bit 0) |
| cfg_wdata | input | 17 | Base, or enable and mask |
| bus_addr | input | 16 | Bus address to decode |
| pri_sel | output | 8 | Main flash sector selects |
| sec_sel | output | 4 | Boot flash sector selects |
| sram_sel | output | 1 | SRAM select |
| io_sel | output | 1 | I/O space select |
| periph_sel | output | 1 | Peripheral space select |
| cfg_err | output | 1 | Sticky configuration-error flag |

## Verification
Two legal maps are swept over all 65,536 addresses and compared with a priority model built from the requirements. The first map tiles the whole space with main flash and stacks boot flash, both SRAM windows, I/O and peripheral on top of it; this separates class priority from plain matching. The second map has sparse windows and a window that was enabled and then disabled, which exposes unmatched holes and stale enables. Directed overlap cases put the address inside two same-class windows, and inside two or three of SRAM, I/O and peripheral. These show the lowest-index or class winner, the error flag being raised and it staying set. Size cases write masks exactly at the sector limit and one bit over it. They cover both flash kinds, disabled writes and SRAM writes, which marks the boundary of the size rule.

// File: rtl/memsel_pkg.sv
`timescale 1ns/1ps
package memsel_pkg;
  localparam int ADDR_W     = 16;
  localparam int PRI_N      = 8;
  localparam int SEC_N      = 4;
  localparam int SRAM_TERMS = 2;
  localparam int SEC_BASE   = PRI_N;
  localparam int SRAM_BASE  = SEC_BASE + SEC_N;
  localparam int IO_IDX     = SRAM_BASE + SRAM_TERMS;
  localparam int PER_IDX    = IO_IDX + 1;
  localparam int NUM_WIN    = PER_IDX + 1;
  localparam int IDX_W      = $clog2(NUM_WIN);

  typedef struct packed {
    logic              en;
    logic [ADDR_W-1:0] mask;
    logic [ADDR_W-1:0] base;
  } win_t;
endpackage

// File: rtl/memsel_rst_sync.sv
`timescale 1ns/1ps
module memsel_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_s_n = sync_q[STAGES-1];
endmodule

// File: rtl/memsel_cfg_regs.sv
`timescale 1ns/1ps
module memsel_cfg_regs
  import memsel_pkg::*;
#(
  parameter int PRI_SECT_AW = 13,
  parameter int SEC_SECT_AW = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [IDX_W:0]  waddr,
  input  logic [ADDR_W:0] wdata,
  output win_t            win [NUM_WIN],
  output logic            size_viol
);
  win_t             win_q [NUM_WIN];
  win_t             win_d [NUM_WIN];
  logic [IDX_W-1:0] widx;
  logic             wfield;
  logic             is_pri;
  logic             is_sec;
  int               zeros;

  assign widx   = waddr[IDX_W:1];
  assign wfield = waddr[0];

  always_comb begin
    for (int i = 0; i < NUM_WIN; i++) win_d[i] = win_q[i];
    if (wfield) begin
      win_d[widx].en   = wdata[ADDR_W];
      win_d[widx].mask = wdata[ADDR_W-1:0];
    end else begin
      win_d[widx].base = wdata[ADDR_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_WIN; i++) win_q[i] <= '0;
    end else if (we) begin
      for (int i = 0; i < NUM_WIN; i++) win_q[i] <= win_d[i];
    end
  end

  // Oversize check: each cleared mask bit doubles the window
  assign zeros  = ADDR_W - $countones(wdata[ADDR_W-1:0]);
  assign is_pri = int'(widx) < SEC_BASE;
  assign is_sec = (int'(widx) >= SEC_BASE) && (int'(widx) < SRAM_BASE);
  assign size_viol = we && wfield && wdata[ADDR_W] &&
                     ((is_pri && (zeros > PRI_SECT_AW)) ||
                      (is_sec && (zeros > SEC_SECT_AW)));

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_out
    assign win[g] = win_q[g];
  end

  // R10: a field write lands in the addressed window
  p_field_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (we && wfield) |=> (win_q[$past(widx)].en == $past(wdata[ADDR_W])) &&
                       (win_q[$past(widx)].mask == $past(wdata[ADDR_W-1:0])));
  p_base_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !wfield) |=> (win_q[$past(widx)].base == $past(wdata[ADDR_W-1:0])));
endmodule

// File: rtl/memsel_window_match.sv
`timescale 1ns/1ps
module memsel_window_match
  import memsel_pkg::*;
(
  input  logic [ADDR_W-1:0]  addr,
  input  win_t               win [NUM_WIN],
  output logic [NUM_WIN-1:0] hit
);
  for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
    assign hit[g] = win[g].en &&
                    ((addr & win[g].mask) == (win[g].base & win[g].mask));
  end
endmodule

// File: rtl/memsel_resolve.sv
`timescale 1ns/1ps
module memsel_resolve
  import memsel_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_WIN-1:0] hit,
  output logic [PRI_N-1:0]   pri_sel,
  output logic [SEC_N-1:0]   sec_sel,
  output logic               sram_sel,
  output logic               io_sel,
  output logic               per_sel,
  output logic               overlap
);
  logic [PRI_N-1:0] pri_hit;
  logic [SEC_N-1:0] sec_hit;
  logic             sram_hit;
  logic             hi_any;

  assign pri_hit  = hit[0 +: PRI_N];
  assign sec_hit  = hit[SEC_BASE +: SEC_N];
  assign sram_hit = |hit[SRAM_BASE +: SRAM_TERMS];
  assign hi_any   = sram_hit || hit[IO_IDX] || hit[PER_IDX];

  always_comb begin
    pri_sel  = '0;
    sec_sel  = '0;
    sram_sel = 1'b0;
    io_sel   = 1'b0;
    per_sel  = 1'b0;
    if (sram_hit)          sram_sel = 1'b1;
    else if (hit[IO_IDX])  io_sel   = 1'b1;
    else if (hit[PER_IDX]) per_sel  = 1'b1;
    else if (|sec_hit)     sec_sel  = sec_hit & (~sec_hit + 1'b1);
    else                   pri_sel  = pri_hit & (~pri_hit + 1'b1);
  end

  assign overlap = ($countones(pri_hit) > 1) || ($countones(sec_hit) > 1) ||
                   ($countones({sram_hit, hit[IO_IDX], hit[PER_IDX]}) > 1);

  p_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({per_sel, io_sel, sram_sel, sec_sel, pri_sel}));
  p_sec_over_pri_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|sec_hit && !hi_any) |-> (pri_sel == '0 && $onehot(sec_sel)));
  p_hi_over_flash_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hi_any |-> (pri_sel == '0 && sec_sel == '0));
  p_no_hit_no_sel_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (hit == '0) |-> ({per_sel, io_sel, sram_sel, sec_sel, pri_sel} == '0));
endmodule

// File: rtl/memsel_err_track.sv
`timescale 1ns/1ps
module memsel_err_track (
  input  logic clk,
  input  logic rst_n,
  input  logic overlap,
  input  logic size_viol,
  output logic err
);
  logic err_q;
  logic err_d;
  logic err_en;

  assign err_en = overlap || size_viol;

  always_comb begin
    err_d = err_q;
    if (err_en) err_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      err_q <= 1'b0;
    else if (err_en) err_q <= err_d;
  end

  assign err = err_q;

  p_overlap_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
    overlap |=> err);
  p_size_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
    size_viol |=> err);
  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);
endmodule

// File: rtl/memsel_decoder.sv
`timescale 1ns/1ps
module memsel_decoder
  import memsel_pkg::*;
#(
  parameter int PRI_SECT_AW = 13,
  parameter int SEC_SECT_AW = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IDX_W:0]    cfg_addr,
  input  logic [ADDR_W:0]   cfg_wdata,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic [PRI_N-1:0]  pri_sel,
  output logic [SEC_N-1:0]  sec_sel,
  output logic              sram_sel,
  output logic              io_sel,
  output logic              periph_sel,
  output logic              cfg_err
);
  logic               rst_s_n;
  win_t               win [NUM_WIN];
  logic [NUM_WIN-1:0] hit;
  logic               size_viol;
  logic               overlap;

  memsel_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_s_n(rst_s_n)
  );

  memsel_cfg_regs #(.PRI_SECT_AW(PRI_SECT_AW), .SEC_SECT_AW(SEC_SECT_AW)) u_cfg (
    .clk(clk), .rst_n(rst_s_n), .we(cfg_we), .waddr(cfg_addr),
    .wdata(cfg_wdata), .win(win), .size_viol(size_viol)
  );

  memsel_window_match u_match (
    .addr(bus_addr), .win(win), .hit(hit)
  );

  memsel_resolve u_res (
    .clk(clk), .rst_n(rst_s_n), .hit(hit), .pri_sel(pri_sel),
    .sec_sel(sec_sel), .sram_sel(sram_sel), .io_sel(io_sel),
    .per_sel(periph_sel), .overlap(overlap)
  );

  memsel_err_track u_err (
    .clk(clk), .rst_n(rst_s_n), .overlap(overlap),
    .size_viol(size_viol), .err(cfg_err)
  );
endmodule

// File: tb/memsel_decoder_bench.sv
`timescale 1ns/1ps
module memsel_decoder_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [4:0]  cfg_addr;
  logic [16:0] cfg_wdata;
  logic [15:0] bus_addr;
  logic [7:0]  pri_sel;
  logic [3:0]  sec_sel;
  logic        sram_sel, io_sel, periph_sel, cfg_err;

  int n_chk  = 0;
  int n_fail = 0;

  logic [15:0] sb [16];
  logic [15:0] sm [16];
  logic        se [16];

  always #2.5 clk = ~clk;

  memsel_decoder u_memsel_decoder (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .bus_addr(bus_addr), .pri_sel(pri_sel),
    .sec_sel(sec_sel), .sram_sel(sram_sel), .io_sel(io_sel),
    .periph_sel(periph_sel), .cfg_err(cfg_err)
  );

  // Select vector: pri 7:0, sec 11:8, sram 12, io 13, periph 14
  function automatic logic [14:0] dut_sel();
    return {periph_sel, io_sel, sram_sel, sec_sel, pri_sel};
  endfunction

  function automatic logic [14:0] ref_sel(input logic [15:0] a);
    logic [15:0] h;
    logic [14:0] r;
    logic        done;
    for (int i = 0; i < 16; i++) h[i] = se[i] && ((a & sm[i]) == (sb[i] & sm[i]));
    r = '0;
    done = 1'b0;
    if (h[12] || h[13])  r[12] = 1'b1;
    else if (h[14])      r[13] = 1'b1;
    else if (h[15])      r[14] = 1'b1;
    else if (|h[11:8]) begin
      for (int i = 8; i < 12; i++) if (h[i] && !done) begin r[i] = 1'b1; done = 1'b1; end
    end else begin
      for (int i = 0; i < 8; i++) if (h[i] && !done) begin r[i] = 1'b1; done = 1'b1; end
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0; bus_addr = 16'hFFFF;
    for (int i = 0; i < 16; i++) begin sb[i] = '0; sm[i] = '0; se[i] = 1'b0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic wr(input int idx, input bit field, input logic [16:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = {idx[3:0], field}; cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
    if (field) begin sm[idx] = data[15:0]; se[idx] = data[16]; end
    else sb[idx] = data[15:0];
  endtask

  task automatic set_win(input int idx, input logic [15:0] base,
                         input logic [15:0] mask, input bit en);
    wr(idx, 1'b0, {1'b0, base});
    wr(idx, 1'b1, {en, mask});
  endtask

  task automatic probe(input logic [15:0] a, input logic [14:0] exp,
                       input string req, input string what);
    @(negedge clk);
    bus_addr = a;
    #1;
    check(dut_sel() == exp, req, what, {17'd0, dut_sel()}, {17'd0, exp});
  endtask

  task automatic sweep(input string req, input string what);
    logic        bad;
    logic [15:0] bad_a;
    logic [14:0] bad_act, bad_exp;
    bad = 1'b0; bad_a = '0; bad_act = '0; bad_exp = '0;
    @(negedge clk);
    for (int a = 0; a < 65536; a++) begin
      bus_addr = a[15:0];
      #0.2;
      if (!bad && dut_sel() != ref_sel(a[15:0])) begin
        bad = 1'b1; bad_a = a[15:0]; bad_act = dut_sel(); bad_exp = ref_sel(a[15:0]);
      end
    end
    if (bad) $display("sweep mismatch at address %h", bad_a);
    check(!bad, req, what, {17'd0, bad_act}, {17'd0, bad_exp});
  endtask

  task automatic chk_err(input logic exp, input string req, input string what);
    @(negedge clk);
    check(cfg_err == exp, req, what, {31'd0, cfg_err}, {31'd0, exp});
  endtask

  task automatic t_reset();
    do_reset();
    probe(16'h0000, '0, "R1", "no select after reset at 0000");
    probe(16'h8123, '0, "R11", "no select after reset at 8123");
    chk_err(1'b0, "R1", "cfg_err clear after reset");
  endtask

  task automatic t_basic();
    do_reset();
    set_win(0, 16'h0000, 16'hE000, 1'b1);
    probe(16'h1234, 15'h0001, "R2", "main sector 0 matches inside window");
    probe(16'h2000, 15'h0000, "R11", "address above window unmatched");
    set_win(9, 16'h5000, 16'hF000, 1'b1);
    probe(16'h5ABC, 15'h0200, "R10", "index 9 drives boot sector 1");
    set_win(14, 16'h7000, 16'hFFF0, 1'b1);
    probe(16'h700F, 15'h2000, "R10", "index 14 drives io");
    set_win(15, 16'h7100, 16'hFF00, 1'b1);
    probe(16'h71FF, 15'h4000, "R10", "index 15 drives peripheral");
    set_win(1, 16'h2000, 16'hE000, 1'b1);
    probe(16'h2100, 15'h0002, "R2", "main sector 1 enabled");
    wr(1, 1'b1, {1'b0, 16'hE000});
    probe(16'h2100, 15'h0000, "R2", "disabled window does not match");
  endtask

  task automatic t_map_a();
    do_reset();
    for (int i = 0; i < 8; i++) set_win(i, 16'(i * 16'h2000), 16'hE000, 1'b1);
    set_win(8, 16'h8000, 16'hF000, 1'b1);
    set_win(9, 16'hF000, 16'hF000, 1'b1);
    set_win(12, 16'h2000, 16'hFF00, 1'b1);
    set_win(13, 16'hC000, 16'hF800, 1'b1);
    set_win(14, 16'h4000, 16'hFFF0, 1'b1);
    set_win(15, 16'h4100, 16'hFF00, 1'b1);
    probe(16'h8010, 15'h0100, "R4", "boot sector 0 over main sector 4");
    probe(16'h9010, 15'h0010, "R4", "main sector 4 outside boot window");
    probe(16'hC010, 15'h1000, "R3", "second SRAM window over main flash");
    probe(16'h2050, 15'h1000, "R5", "first SRAM window over main sector 1");
    probe(16'h4005, 15'h2000, "R5", "io over main sector 2");
    probe(16'h4150, 15'h4000, "R5", "peripheral over main sector 2");
    sweep("R6", "full sweep of layered map");
    chk_err(1'b0, "R7", "legal layered map raises no error");
  endtask

  task automatic t_map_b();
    do_reset();
    set_win(0, 16'h0000, 16'hE000, 1'b1);
    set_win(5, 16'hA000, 16'hE000, 1'b1);
    set_win(10, 16'hA800, 16'hF800, 1'b1);
    set_win(11, 16'h0000, 16'hFF00, 1'b1);
    set_win(3, 16'h6000, 16'hE000, 1'b1);
    wr(3, 1'b1, {1'b0, 16'hE000});
    set_win(13, 16'hE000, 16'hFFC0, 1'b1);
    sweep("R11", "full sweep of sparse map");
    chk_err(1'b0, "R7", "sparse map raises no error");
  endtask

  task automatic t_pri_overlap();
    do_reset();
    set_win(0, 16'h0000, 16'hE000, 1'b1);
    set_win(1, 16'h0000, 16'hE000, 1'b1);
    chk_err(1'b0, "R7", "no error while address outside overlap");
    probe(16'h0100, 15'h0001, "R6", "lowest main index wins");
    chk_err(1'b1, "R7", "main overlap at address flags error");
    @(negedge clk); bus_addr = 16'h8000;
    repeat (3) @(negedge clk);
    chk_err(1'b1, "R9", "error stays set after leaving overlap");
  endtask

  task automatic t_sec_overlap();
    do_reset();
    set_win(10, 16'h3000, 16'hF000, 1'b1);
    set_win(11, 16'h3800, 16'hF800, 1'b1);
    probe(16'h3900, 15'h0400, "R6", "lowest boot index wins");
    chk_err(1'b1, "R7", "boot overlap flags error");
  endtask

  task automatic t_hi_overlap();
    do_reset();
    set_win(12, 16'h3000, 16'hFF00, 1'b1);
    set_win(14, 16'h3000, 16'hFF00, 1'b1);
    set_win(15, 16'h3000, 16'hFF00, 1'b1);
    probe(16'h3010, 15'h1000, "R5", "SRAM wins over io and peripheral");
    chk_err(1'b1, "R7", "SRAM io peripheral overlap flags error");
    do_reset();
    set_win(14, 16'h3000, 16'hFF00, 1'b1);
    set_win(15, 16'h3000, 16'hFF00, 1'b1);
    probe(16'h30AA, 15'h2000, "R5", "io wins over peripheral");
    chk_err(1'b1, "R7", "io peripheral overlap flags error");
  endtask

  task automatic t_sram_terms();
    do_reset();
    set_win(12, 16'h6000, 16'hF000, 1'b1);
    set_win(13, 16'h6800, 16'hF800, 1'b1);
    probe(16'h6100, 15'h1000, "R3", "first SRAM window alone");
    probe(16'h6900, 15'h1000, "R3", "both SRAM windows");
    chk_err(1'b0, "R3", "SRAM windows overlapping each other are legal");
  endtask

  task automatic t_size();
    do_reset();
    set_win(2, 16'h4000, 16'hE000, 1'b1);
    chk_err(1'b0, "R8", "main mask at sector limit accepted");
    set_win(9, 16'h8000, 16'hF000, 1'b1);
    chk_err(1'b0, "R8", "boot mask at sector limit accepted");
    set_win(3, 16'h0000, 16'hC000, 1'b0);
    chk_err(1'b0, "R8", "oversize write with enable 0 ignored");
    set_win(12, 16'h0000, 16'h0000, 1'b1);
    chk_err(1'b0, "R8", "large SRAM window not size checked");
    set_win(4, 16'h0000, 16'hC000, 1'b1);
    check(cfg_err == 1'b1, "R8", "main mask one bit over limit", {31'd0, cfg_err}, 32'd1);
    do_reset();
    set_win(10, 16'h0000, 16'hE000, 1'b1);
    check(cfg_err == 1'b1, "R8", "boot mask one bit over limit", {31'd0, cfg_err}, 32'd1);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_basic();
        t_map_a();
        t_map_b();
        t_pri_overlap();
        t_sec_overlap();
        t_hi_overlap();
        t_sram_terms();
        t_size();
      end
      begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule